// File: doc/BRIEF.md
# Embedded-Clock Frame Serializer

This block turns a 10-bit parallel word into a 12-bit serial frame on a bit clock that runs twelve times faster than the word rate. Every frame opens with a framing bit fixed at one and closes with a framing bit fixed at zero. The line therefore changes level at every frame boundary, and a receiver can recover the word clock from the serial stream alone. A modulo-12 slot counter inside the block produces the word clock (`word_clk`), which the data source uses to present words. A run-time select decides whether a word is sampled on the rising or the falling edge of that clock.

Two synchronization request inputs are sampled once per frame. When either of them has been high for five frames in a row, the block stops sending data and sends a training frame instead: six ones followed by six zeros. It keeps doing so until a frame boundary where both requests are low. The serial output is only enabled when the external PLL-ready indication and the drive enable are both high. At all other times the output-enable flag is low, which stands for high impedance, and the data line is held at zero.

Top module: `emb_frame_ser`

## Requirements
- R1: A frame has 12 bit slots numbered 0 to 11, one slot per clock. After reset the block is in slot 0. `word_clk` is high during slots 0–5 and low during slots 6–11.
- R2: Slot 0 of every frame carries a one and slot 11 carries a zero.
- R3: In a data frame, bit i of the captured word is carried in slot i+1, for i = 0 to 9.
- R4: A training frame carries ones in slots 0–5 and zeros in slots 6–11.
- R5: The sync requests are sampled at the end of slot 11. The frame loaded at the sample where either request has been high for the 5th consecutive sample is a training frame. Four consecutive high samples produce no training frame.
- R6: Training frames continue while either request stays high. The first sample with both requests low loads a data frame again.
- R7: With `cap_rise`=1, `par_data` is captured at the end of slot 11 (the rising edge of `word_clk`). With `cap_rise`=0, it is captured at the end of slot 5 (the falling edge of `word_clk`).
- R8: A captured word is moved into the shift register only at the end of slot 11. A word captured at the end of slot 5 goes out in the next frame. A word captured at the end of slot 11 goes out in the frame after that.
- R9: `ser_oe` equals `pll_ready` AND `drv_en`, and `ser_out` is 0 whenever `ser_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, twelve per word |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_data | input | 10 | Parallel word to send |
| sync_req_a | input | 1 | Synchronization request, first source |
| sync_req_b | input | 1 | Synchronization request, second source |
| cap_rise | input | 1 | 1: capture on rising word-clock edge, 0: on falling edge |
| drv_en | input | 1 | Drive enable for the serial output |
| pll_ready | input | 1 | Clock-source locked indication |
| word_clk | output | 1 | Word clock derived from the slot counter |
| ser_out | output | 1 | Serial frame bit |
| ser_oe | output | 1 | Serial output enable (0 means high impedance) |

## Verification
The bench builds the block with its default parameters: a 10-bit word, a 12-slot frame and a sync hold of five frames. With a hold of five, both sides of the threshold can be reached in a few dozen frames, so the bench shows both a four-frame request (no training) and a five-frame request (training). Words are also switched between slot halves so that the two capture edges give different frames, and the words used include all ones and all zeros. Together these cover both capture latencies, the training entry and exit, and the framing bits.

// File: rtl/fs_pkg.sv
package fs_pkg;
  localparam int FS_DATA_W    = 10;
  localparam int FS_SYNC_HOLD = 5;
  typedef enum logic {CAP_FALL = 1'b0, CAP_RISE = 1'b1} cap_edge_e;
endpackage

// File: rtl/fs_timer.sv
module fs_timer #(
  parameter int FRAME_W = 12,
  localparam int CNT_W  = $clog2(FRAME_W),
  localparam int HALF   = FRAME_W / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] slot,
  output logic             boundary,
  output logic             fall_pt,
  output logic             word_clk
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(HALF - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + CNT_W'(1);
  end

  assign slot     = cnt;
  assign boundary = (cnt == LAST);
  assign fall_pt  = (cnt == MID);
  assign word_clk = (cnt < CNT_W'(HALF));

  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (slot == '0));
  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> (slot == $past(slot) + CNT_W'(1)));
  p_wclk_r1: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> $rose(word_clk));
endmodule

// File: rtl/fs_capture.sv
module fs_capture #(
  parameter int DATA_W    = 10,
  parameter int SYNC_HOLD = 5,
  localparam int SC_W     = $clog2(SYNC_HOLD + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] par_data,
  input  logic              sync_req_a,
  input  logic              sync_req_b,
  input  logic              cap_rise,
  input  logic              boundary,
  input  logic              fall_pt,
  output logic [DATA_W-1:0] hold_word,
  output logic              train_go
);
  import fs_pkg::*;

  localparam logic [SC_W-1:0] HOLD = SC_W'(SYNC_HOLD);

  logic [SC_W-1:0] sc;
  logic [SC_W-1:0] sc_next;
  logic            sync_any;
  logic            cap_ev;
  cap_edge_e       edge_sel;

  function automatic logic [SC_W-1:0] next_count(input logic req, input logic [SC_W-1:0] c);
    if (!req) return '0;
    if (c >= HOLD) return HOLD;
    return c + SC_W'(1);
  endfunction

  assign edge_sel = cap_edge_e'(cap_rise);
  assign cap_ev   = (edge_sel == CAP_RISE) ? boundary : fall_pt;
  assign sync_any = sync_req_a | sync_req_b;
  assign sc_next  = next_count(sync_any, sc);
  assign train_go = (sc_next >= HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc        <= '0;
      hold_word <= '0;
    end else begin
      if (boundary) sc <= sc_next;
      if (cap_ev) hold_word <= par_data;
    end
  end

  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !sync_req_a && !sync_req_b) |-> !train_go);
  p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_ev |=> $stable(hold_word));
  p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ev |=> (hold_word == $past(par_data)));
endmodule

// File: rtl/fs_shifter.sv
module fs_shifter #(
  parameter int DATA_W  = 10,
  localparam int FRAME_W = DATA_W + 2,
  localparam int CNT_W   = $clog2(FRAME_W),
  localparam int HALF    = FRAME_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary,
  input  logic [CNT_W-1:0]  slot,
  input  logic [DATA_W-1:0] hold_word,
  input  logic              train_go,
  output logic              line
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  function automatic logic [FRAME_W-1:0] frame_of(input logic [DATA_W-1:0] d);
    return {1'b0, d, 1'b1};
  endfunction

  function automatic logic [FRAME_W-1:0] train_vec();
    logic [FRAME_W-1:0] v;
    for (int i = 0; i < FRAME_W; i++) v[i] = (i < HALF);
    return v;
  endfunction

  logic [FRAME_W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= frame_of('0);
    else if (boundary) sr <= train_go ? train_vec() : frame_of(hold_word);
    else sr <= {1'b0, sr[FRAME_W-1:1]};
  end

  assign line = sr[0];

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == '0) |-> line);
  p_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == LAST) |-> !line);
  p_train_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && train_go) |=> (sr == train_vec()));
  p_data_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !train_go) |=> (sr[DATA_W:1] == $past(hold_word)));
endmodule

// File: rtl/emb_frame_ser.sv
module emb_frame_ser #(
  parameter int DATA_W    = fs_pkg::FS_DATA_W,
  parameter int SYNC_HOLD = fs_pkg::FS_SYNC_HOLD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] par_data,
  input  logic              sync_req_a,
  input  logic              sync_req_b,
  input  logic              cap_rise,
  input  logic              drv_en,
  input  logic              pll_ready,
  output logic              word_clk,
  output logic              ser_out,
  output logic              ser_oe
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int CNT_W   = $clog2(FRAME_W);

  logic [CNT_W-1:0]  slot;
  logic              boundary;
  logic              fall_pt;
  logic [DATA_W-1:0] hold_word;
  logic              train_go;
  logic              line;

  fs_timer #(.FRAME_W(FRAME_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .slot(slot), .boundary(boundary),
    .fall_pt(fall_pt), .word_clk(word_clk)
  );

  fs_capture #(.DATA_W(DATA_W), .SYNC_HOLD(SYNC_HOLD)) u_cap (
    .clk(clk), .rst_n(rst_n), .par_data(par_data), .sync_req_a(sync_req_a),
    .sync_req_b(sync_req_b), .cap_rise(cap_rise), .boundary(boundary),
    .fall_pt(fall_pt), .hold_word(hold_word), .train_go(train_go)
  );

  fs_shifter #(.DATA_W(DATA_W)) u_shf (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .slot(slot),
    .hold_word(hold_word), .train_go(train_go), .line(line)
  );

  assign ser_oe  = pll_ready & drv_en;
  assign ser_out = ser_oe & line;

  p_hiz_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pll_ready || !drv_en) |-> (!ser_oe && !ser_out));
endmodule

// File: tb/sim_emb_frame_ser.sv
module sim_emb_frame_ser;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] par_data = '0;
  logic       sync_req_a = 1'b0, sync_req_b = 1'b0;
  logic       cap_rise = 1'b1, drv_en = 1'b1, pll_ready = 1'b0;
  logic       word_clk, ser_out, ser_oe;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  emb_frame_ser u0 (
    .clk(clk), .rst_n(rst_n), .par_data(par_data), .sync_req_a(sync_req_a),
    .sync_req_b(sync_req_b), .cap_rise(cap_rise), .drv_en(drv_en),
    .pll_ready(pll_ready), .word_clk(word_clk), .ser_out(ser_out), .ser_oe(ser_oe)
  );

  always #5 clk = ~clk;

  // behavioural reference model
  int          m_slot, m_sync;
  logic [9:0]  m_hold;
  logic [11:0] m_frame;
  logic [11:0] TRAIN = 12'b0000_0011_1111;

  function automatic logic [11:0] mk(input logic [9:0] d);
    logic [11:0] f;
    f[0] = 1'b1;
    for (int i = 0; i < 10; i++) f[i+1] = d[i];
    f[11] = 1'b0;
    return f;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_slot = 0; m_sync = 0; m_hold = '0; m_frame = mk('0);
    end else begin
      if (m_slot == 11) begin
        if (sync_req_a || sync_req_b) m_sync = (m_sync >= 5) ? 5 : m_sync + 1;
        else m_sync = 0;
        m_frame = (m_sync >= 5) ? TRAIN : mk(m_hold);
      end
      if (cap_rise ? (m_slot == 11) : (m_slot == 5)) m_hold = par_data;
      m_slot = (m_slot == 11) ? 0 : m_slot + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic eo, eb;
      string tg;
      eo = pll_ready & drv_en;
      eb = eo & m_frame[m_slot];
      if (m_frame == TRAIN) tg = "R4 slot bit";
      else if (m_slot == 0 || m_slot == 11) tg = "R2 framing bit";
      else tg = "R3 data bit";
      chk(word_clk === (m_slot < 6), "R1 word_clk", {11'b0, word_clk}, {11'b0, (m_slot < 6)});
      chk(ser_oe === eo, "R9 ser_oe", {11'b0, ser_oe}, {11'b0, eo});
      chk(ser_out === eb, tg, {11'b0, ser_out}, {11'b0, eb});
    end
  end

  // frame monitor
  logic [11:0] obs, last_frame;
  int train_seen = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      obs[m_slot] = ser_out;
      if (m_slot == 11) begin
        last_frame = obs;
        if (obs == TRAIN) train_seen++;
      end
    end
  end

  // alternate-half data driver for capture edge test
  bit alt_mode = 0;
  logic [9:0] alt_a = 10'h0F0, alt_b = 10'h30C;
  always @(negedge clk) if (alt_mode) par_data <= (m_slot >= 6) ? alt_a : alt_b;

  task automatic wait_slot(input int k);
    do @(negedge clk); while (m_slot != k);
  endtask

  task automatic wait_frames(input int n);
    for (int i = 0; i < n; i++) wait_slot(11);
    #1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(word_clk === 1'b1, "R1 reset slot 0", {11'b0, word_clk}, 12'h001);
    chk(ser_oe === 1'b0, "R9 reset not ready", {11'b0, ser_oe}, 12'h000);
    rst_n = 1'b1;
    repeat (30) @(negedge clk);
    chk(ser_oe === 1'b0 && ser_out === 1'b0, "R9 hold-off", {10'b0, ser_oe, ser_out}, 12'h000);
    pll_ready = 1'b1;

    // R3 / R2 data patterns
    foreach (alt_a[i]) ;
    begin
      logic [9:0] pats [4] = '{10'h2A5, 10'h155, 10'h3FF, 10'h000};
      for (int p = 0; p < 4; p++) begin
        par_data = pats[p];
        wait_frames(3);
        chk(last_frame === mk(pats[p]), "R3 frame", last_frame, mk(pats[p]));
        chk(last_frame[0] === 1'b1 && last_frame[11] === 1'b0, "R2 start/stop",
            last_frame, mk(pats[p]));
      end
    end

    // R8 latency, rising capture
    par_data = 10'h111; wait_frames(3);
    wait_slot(0); par_data = 10'h2C3;
    wait_frames(1);
    chk(last_frame === mk(10'h111), "R8 frame N old", last_frame, mk(10'h111));
    wait_frames(1);
    chk(last_frame === mk(10'h111), "R8 frame N+1 old", last_frame, mk(10'h111));
    wait_frames(1);
    chk(last_frame === mk(10'h2C3), "R8 frame N+2 new", last_frame, mk(10'h2C3));

    // R8 latency, falling capture
    cap_rise = 1'b0; par_data = 10'h111; wait_frames(3);
    wait_slot(0); par_data = 10'h0AB;
    wait_frames(1);
    chk(last_frame === mk(10'h111), "R8 fall frame N old", last_frame, mk(10'h111));
    wait_frames(1);
    chk(last_frame === mk(10'h0AB), "R8 fall frame N+1 new", last_frame, mk(10'h0AB));

    // R7 capture edge select
    alt_mode = 1; cap_rise = 1'b1; wait_frames(3);
    chk(last_frame === mk(alt_a), "R7 rising edge", last_frame, mk(alt_a));
    cap_rise = 1'b0; wait_frames(3);
    chk(last_frame === mk(alt_b), "R7 falling edge", last_frame, mk(alt_b));
    alt_mode = 0; cap_rise = 1'b1;
    @(negedge clk); par_data = 10'h2A5; wait_frames(3);

    // R5 four samples: no training
    train_seen = 0;
    wait_slot(0); sync_req_a = 1'b1;
    wait_frames(4); wait_slot(0); sync_req_a = 1'b0;
    wait_frames(4);
    chk(train_seen == 0, "R5 four samples no training", 12'(train_seen), 12'h000);

    // R5 five samples: training
    wait_slot(0); sync_req_b = 1'b1;
    wait_frames(5);
    chk(train_seen == 0, "R5 not before 5th sample", 12'(train_seen), 12'h000);
    wait_frames(2);
    chk(last_frame === TRAIN, "R4 training frame", last_frame, TRAIN);
    chk(train_seen > 0, "R5 training after 5 samples", 12'(train_seen), 12'h001);

    // R6 one request keeps training, both low ends it
    sync_req_a = 1'b1; wait_frames(1); sync_req_b = 1'b0;
    wait_frames(3);
    chk(last_frame === TRAIN, "R6 one request held", last_frame, TRAIN);
    sync_req_a = 1'b0;
    wait_frames(3);
    chk(last_frame === mk(10'h2A5), "R6 release to data", last_frame, mk(10'h2A5));

    // R9 drive enable
    drv_en = 1'b0;
    repeat (5) @(negedge clk);
    chk(ser_oe === 1'b0 && ser_out === 1'b0, "R9 enable low", {10'b0, ser_oe, ser_out}, 12'h000);
    drv_en = 1'b1;
    wait_frames(2);
    chk(last_frame === mk(10'h2A5), "R9 enable restored", last_frame, mk(10'h2A5));

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule